// File: doc/BRIEF.md
# Program-Busy Status Read Generator

This block sits in the read path of a sector-programmed flash memory. While an internal program cycle runs (`busy_i` high), the array cannot be read. A host that reads the memory during that time gets a status word instead of stored data. The status word carries two indicators in each byte lane of the 16-bit word:

- a **polling bit**: the top bit of the lane, returned inverted from the last word that was loaded;
- a **toggle bit**: the next bit down, which flips on each new read access.

A host tracks progress by watching either indicator. When `busy_i` falls, reads return the true array word at once.

A read access exists while chip enable and output enable are both low and write enable is high. A new access begins each time that condition becomes true after being false. The bus driver is enabled only during an access. At all other times the data output is held at zero, and an external pad drives it to high impedance.

Top module: `busy_status_rdgen`

## Requirements
- R1: `bus_oe_o` is 1 exactly when `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1; whenever `bus_oe_o` is 0, `bus_data_o` is 0.
- R2: During an access with `busy_i`=0, `bus_data_o` equals `array_data_i` on all 16 bits.
- R3: During an access with `busy_i`=1, bit 7 of `bus_data_o` is the inverse of bit 7 of `last_word_i`, and bit 15 is the inverse of bit 15.
- R4: During an access with `busy_i`=1, every bit other than 6, 7, 14 and 15 equals the same bit of `last_word_i`.
- R5: During an access with `busy_i`=1, bits 6 and 14 are equal to each other, and they keep one value for the whole of that access.
- R6: Within one busy period, each new access shows bits 6 and 14 inverted relative to the previous access. An access starts when the strobe becomes active after a cycle in which it was inactive, and this includes a low pulse on `we_n_i` alone.
- R7: The toggle state is cleared when `busy_i` rises. The first access of a busy period therefore shows 1 on bits 6 and 14. Accesses made while `busy_i`=0 do not advance the toggle state.
- R8: In the first cycle in which `busy_i` is 0, an ongoing access returns true array data, with no extra cycle of status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal program cycle in progress |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| last_word_i | input | 16 | Last data word loaded for programming |
| array_data_i | input | 16 | True array read data |
| bus_data_o | output | 16 | Data word presented to the bus |
| bus_oe_o | output | 1 | Bus driver enable |

## Verification
The hardest situations to reach are those where a read begins in the same cycle as another event. One is a read starting in the cycle that `busy_i` rises. Another is a read whose strobe is broken by a single-cycle write-enable pulse while chip enable and output enable stay low.

The stimulus creates these edges on purpose, alongside long continuous reads that span the fall of `busy_i`. A behavioural model in the bench tracks the previous strobe, the previous busy level and the toggle value, and predicts every output bit on every cycle.

// File: rtl/busy_rd_pkg.sv
package busy_rd_pkg;

    // Registered edge-detect history for the read strobe and busy flag
    typedef struct packed {
        logic rd;
        logic busy;
    } edge_hist_t;

    // Toggle state register
    typedef struct packed {
        logic tgl;
    } tgl_state_t;

endpackage

// File: rtl/brd_strobe_track.sv
module brd_strobe_track
    import busy_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic busy,
    output logic rd_act,
    output logic rd_start,
    output logic busy_rise
);

    edge_hist_t hist_d, hist_q;

    always_comb begin
        rd_act      = ~ce_n & ~oe_n & we_n;
        rd_start    = rd_act & ~hist_q.rd;
        busy_rise   = busy & ~hist_q.busy;
        hist_d      = hist_q;
        hist_d.rd   = rd_act;
        hist_d.busy = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // R6: a start marks the first cycle of an access only
    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start || !rd_act || 1'b1 ? !(rd_start && $past(rd_act)) : 1'b1);

    // R1: no access while write enable is low
    assert_no_read_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !rd_act);

endmodule

// File: rtl/brd_toggle_gen.sv
module brd_toggle_gen
    import busy_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_start,
    input  logic busy_rise,
    output logic tgl_show
);

    tgl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_rise)
            st_d.tgl = rd_start;
        else if (busy && rd_start)
            st_d.tgl = ~st_q.tgl;
        tgl_show = st_d.tgl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: busy rise with no access clears the toggle
    assert_clear_on_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_rise && !rd_start) |=> (st_q.tgl == 1'b0));

    // R7: idle reads leave toggle untouched
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !busy_rise) |=> $stable(st_q.tgl));

    // R6: each new access within a busy period flips the toggle
    assert_flip_per_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_rise && rd_start) |=> (st_q.tgl != $past(st_q.tgl)));

endmodule

// File: rtl/brd_lane_mux.sv
module brd_lane_mux #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              rd_act,
    input  logic              busy,
    input  logic              tgl,
    input  logic [LANE_W-1:0] last_lane,
    input  logic [LANE_W-1:0] arr_lane,
    output logic [LANE_W-1:0] out_lane
);

    localparam int unsigned POLL_POS = LANE_W - 1;
    localparam int unsigned TGL_POS  = LANE_W - 2;

    logic [LANE_W-1:0] status_w;

    always_comb begin
        status_w           = last_lane;
        status_w[POLL_POS] = ~last_lane[POLL_POS];
        status_w[TGL_POS]  = tgl;
        if (!rd_act)
            out_lane = '0;
        else if (busy)
            out_lane = status_w;
        else
            out_lane = arr_lane;
    end

    // R3: polling bit is inverted relative to the loaded word while busy
    always_comb begin
        if (rd_act && busy)
            assert_poll_inv_R3: assert (out_lane[POLL_POS] != last_lane[POLL_POS]);
    end

endmodule

// File: rtl/busy_status_rdgen.sv
module busy_status_rdgen #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [DATA_W-1:0] last_word_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_oe_o
);

    localparam int unsigned NUM_LANES = DATA_W / LANE_W;
    localparam int unsigned LO_TGL    = LANE_W - 2;
    localparam int unsigned HI_TGL    = DATA_W - 2;

    logic rd_act, rd_start, busy_rise, tgl_show;
    logic past_ok_q;

    brd_strobe_track u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n_i),
        .oe_n      (oe_n_i),
        .we_n      (we_n_i),
        .busy      (busy_i),
        .rd_act    (rd_act),
        .rd_start  (rd_start),
        .busy_rise (busy_rise)
    );

    brd_toggle_gen u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy_i),
        .rd_start  (rd_start),
        .busy_rise (busy_rise),
        .tgl_show  (tgl_show)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        brd_lane_mux #(.LANE_W(LANE_W)) u_mux (
            .rd_act    (rd_act),
            .busy      (busy_i),
            .tgl       (tgl_show),
            .last_lane (last_word_i[g*LANE_W +: LANE_W]),
            .arr_lane  (array_data_i[g*LANE_W +: LANE_W]),
            .out_lane  (bus_data_o[g*LANE_W +: LANE_W])
        );
    end

    assign bus_oe_o = rd_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R1: idle bus carries zero
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_data_o == '0));

    // R2: not busy returns the array word
    assert_true_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && !busy_i) |-> (bus_data_o == array_data_i));

    // R5: toggle bits agree across lanes
    assert_lanes_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && busy_i) |-> (bus_data_o[LO_TGL] == bus_data_o[HI_TGL]));

    // R5: toggle bits hold through one continuous access
    assert_hold_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && bus_oe_o && busy_i && $past(bus_oe_o) && $past(busy_i))
            |-> $stable(bus_data_o[LO_TGL]));

endmodule

// File: tb/busy_status_rdgen_tb.sv
module busy_status_rdgen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy_i = 1'b0;
    logic        ce_n_i = 1'b1;
    logic        oe_n_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic [15:0] last_word_i = '0;
    logic [15:0] array_data_i = '0;
    logic [15:0] bus_data_o;
    logic        bus_oe_o;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    bit m_rd_prev = 0, m_busy_prev = 0, m_tgl = 0;
    int m_reads_in_busy = 0;
    bit prev_show_valid = 0;
    bit prev_show = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busy_status_rdgen u_dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .ce_n_i(ce_n_i),
        .oe_n_i(oe_n_i), .we_n_i(we_n_i), .last_word_i(last_word_i),
        .array_data_i(array_data_i), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs against model, then advance model at the clock edge
    task automatic step(input bit was_busy_before);
        bit rd, start, brise, tn;
        logic [15:0] exp, st;
        string ttag;
        rd    = !ce_n_i && !oe_n_i && we_n_i;
        start = rd && !m_rd_prev;
        brise = busy_i && !m_busy_prev;
        if (brise)                tn = start;
        else if (busy_i && start) tn = !m_tgl;
        else                      tn = m_tgl;
        #(CLK_PERIOD/4);
        chk("R1 oe", {15'd0, bus_oe_o}, {15'd0, rd});
        if (!rd) chk("R1 idle data", bus_data_o, 16'h0);
        else if (!busy_i) chk(was_busy_before ? "R8 release" : "R2 array", bus_data_o, array_data_i);
        else begin
            st = last_word_i;
            st[7] = ~last_word_i[7]; st[15] = ~last_word_i[15];
            st[6] = tn; st[14] = tn;
            exp = st;
            chk("R3 poll", bus_data_o & 16'h8080, exp & 16'h8080);
            chk("R4 others", bus_data_o & 16'h3F3F, exp & 16'h3F3F);
            if (start && m_reads_in_busy == 0) ttag = "R7 first";
            else if (start) ttag = "R6 flip";
            else ttag = "R5 hold";
            chk(ttag, bus_data_o & 16'h4040, exp & 16'h4040);
        end
        @(posedge clk);
        if (brise) m_reads_in_busy = 0;
        if (busy_i && start) m_reads_in_busy++;
        m_tgl = tn; m_rd_prev = rd; m_busy_prev = busy_i;
        @(negedge clk);
    endtask

    task automatic cyc(input bit b, input bit ce, input bit oe, input bit we, input int n);
        for (int i = 0; i < n; i++) begin
            bit wb;
            wb = busy_i;
            busy_i = b; ce_n_i = ce; oe_n_i = oe; we_n_i = we;
            last_word_i = 16'hA5C3 ^ 16'(i * 16'h0111);
            array_data_i = 16'h1E2D + 16'(i * 7);
            step(wb && !b);
        end
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        chk("R1 reset", {bus_oe_o, bus_data_o[14:0]}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // idle reads, not busy (R2), and WE low blocks access (R1)
        cyc(0, 0, 0, 1, 4);
        cyc(0, 0, 0, 0, 2);
        cyc(0, 1, 0, 1, 2);
        cyc(0, 0, 1, 1, 2);
        // idle reads must not advance toggle; busy rises with no access (R7)
        cyc(1, 1, 1, 1, 2);
        cyc(1, 0, 0, 1, 3);   // first read shows 1, held (R5)
        cyc(1, 1, 0, 1, 1);
        cyc(1, 0, 0, 1, 2);   // flip (R6)
        cyc(1, 0, 0, 0, 1);   // WE pulse breaks access
        cyc(1, 0, 0, 1, 2);   // flip again (R6)
        cyc(1, 0, 1, 1, 1);
        cyc(1, 0, 0, 1, 1);
        // busy falls during continuous access (R8)
        cyc(1, 0, 0, 1, 2);
        cyc(0, 0, 0, 1, 3);
        // read begins same cycle as busy rise (R7)
        cyc(0, 1, 1, 1, 2);
        cyc(1, 0, 0, 1, 3);
        for (int k = 0; k < 6; k++) begin
            cyc(1, 1, 1, 1, 1);
            cyc(1, 0, 0, 1, 2);
        end
        cyc(0, 0, 0, 1, 2);
        cyc(0, 1, 1, 1, 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule